// File: doc/BRIEF.md
# S/PDIF Subframe Biphase-Mark Encoder

This block turns a stream of stereo 16-bit PCM frames into one serial S/PDIF line. Every audio sample is placed in a 32-slot subframe: an 8-cell synchronisation preamble, four auxiliary slots, a 20-slot audio field with the sample in its upper 16 slots, and the V, U, C and P flags. Each slot after the preamble is biphase-mark coded into two line cells, so a subframe is 64 cells. One cell is emitted for each cycle in which the cell-rate enable `cell_en` is high. The enable therefore runs at 64 times twice the sample rate.

A subframe index runs from 0 to 383, which is 192 stereo frames, and then wraps. Index 0 carries the block-start preamble. The other odd indices carry the right-channel preamble, and the other even indices carry the left-channel preamble. The first auxiliary slot is given a value that makes the parity of slots 4 to 31 even, so the parity flag is always sent as 0. Because of this, the line is always low when a preamble begins, and the fixed preamble patterns can be sent without any further correction.

Frames arrive on a valid/ready input. The block is ready only at the first cell of a left subframe, and it takes the left and right samples together in that cycle. A source that cannot supply a frame at that moment does not stall the line. The encoder sends a zero sample with the validity flag set and keeps sending preambles, so a receiver stays locked.

Top module: `spdif_subframe_enc`

## Requirements
- R1: After reset `sdo` is low and `in_ready` is low. The first subframe after reset has index 0 and carries the block-start preamble.
- R2: Each subframe begins with 8 preamble cells, sent most significant bit first. The pattern is 8'hE8 when the subframe index is 0, 8'hE4 when the index is odd, and 8'hE2 for any other even index. The index counts 0 to 383 and then returns to 0.
- R3: Preamble cells are the pattern XORed with the line level just before the preamble. The parity folding (R6) keeps that level low at the start of every subframe.
- R4: Each of slots 4 to 31 is sent as two cells. The first cell always inverts the line level. The second cell inverts it again when the slot value is 1 and holds it when the value is 0.
- R5: Data slots are placed in time order as follows:
  - slot 4: the parity-fold bit;
  - slots 5 to 11: 0;
  - slots 12 to 27: the 16-bit sample, least significant bit first;
  - slot 28: the validity flag V (1 means invalid);
  - slots 29, 30 and 31: U, C and P, each sent as 0.
- R6: Slot 4 equals the XOR of all sample bits and V. The P slot is always 0, and the number of ones in slots 4 to 31 is even.
- R7: `in_ready` is high only in a cycle where `cell_en` is high and the block is at the first cell of an even-index subframe. A frame is accepted when `in_valid` and `in_ready` are both high. Its left sample goes into that subframe and its right sample into the next (odd-index) subframe.
- R8: If no frame is accepted at the start of a left subframe, that subframe and the right subframe after it each carry a zero sample with V=1.
- R9: `mute` is sampled at the first cell of each subframe. When it is high, that subframe is sent with V=1 and its sample unchanged.
- R10: While `cell_en` is low, `sdo` holds its level and no cell, slot or subframe position advances.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_en | input | 1 | One line cell is emitted in each cycle where this is high |
| mute | input | 1 | Marks the subframe being started as invalid |
| in_valid | input | 1 | A stereo frame is offered |
| in_ready | output | 1 | The frame is taken in this cycle |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| sdo | output | 1 | Biphase-mark coded serial line |

## Verification
The bench decodes every 64-cell subframe from `sdo` and compares it with the frame it expects for that subframe. A wrong subframe index shows up at the preamble of the next subframe as the wrong pattern, or as a misplaced block start after up to 384 subframes. A parity or polarity error appears within one subframe, either as a preamble entered from a high line level or as a missing transition at the start of a slot. A fault in the handshake or in the right-sample holding register changes the decoded samples and V flags of the left/right pair in which it happens.

// File: rtl/spdif_enc_pkg.sv
`timescale 1ns/1ps
package spdif_enc_pkg;
  localparam int CELLS_PER_SF = 64;
  localparam int PRE_CELLS    = 8;
  localparam int DATA_SLOTS   = 28;
  localparam int AUX_SLOTS    = 4;
  localparam int AUDIO_SLOTS  = 20;
  localparam int V_SLOT       = AUX_SLOTS + AUDIO_SLOTS;   // data index of V

  typedef enum logic [1:0] {PRE_B = 2'd0, PRE_M = 2'd1, PRE_W = 2'd2} pre_kind_e;

  // Preamble cell patterns, sent MSB first, for a low incoming line level.
  function automatic logic [7:0] pre_cells(input pre_kind_e k);
    case (k)
      PRE_B:   pre_cells = 8'hE8;
      PRE_W:   pre_cells = 8'hE4;
      default: pre_cells = 8'hE2;
    endcase
  endfunction
endpackage

// File: rtl/spdif_enc_seq.sv
`timescale 1ns/1ps
module spdif_enc_seq
  import spdif_enc_pkg::*;
#(
  parameter int SF_PER_BLOCK = 384
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cell_en,
  output logic [5:0] pos,
  output logic       sf_start,
  output logic       is_left,
  output pre_kind_e  kind
);
  localparam int IDX_W = $clog2(SF_PER_BLOCK);
  localparam logic [IDX_W-1:0] LAST_SF = IDX_W'(SF_PER_BLOCK - 1);
  localparam logic [5:0] LAST_CELL = 6'(CELLS_PER_SF - 1);

  logic [IDX_W-1:0] sf_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      sf_idx <= '0;
    end else if (cell_en) begin
      pos <= pos + 6'd1;
      if (pos == LAST_CELL)
        sf_idx <= (sf_idx == LAST_SF) ? '0 : sf_idx + 1'b1;
    end
  end

  always_comb begin
    sf_start = (pos == 6'd0);
    is_left  = ~sf_idx[0];
    if (sf_idx == '0)   kind = PRE_B;
    else if (sf_idx[0]) kind = PRE_W;
    else                kind = PRE_M;
  end

  // R2
  block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && pos == LAST_CELL && sf_idx == LAST_SF |=> kind == PRE_B);
endmodule

// File: rtl/spdif_enc_build.sv
`timescale 1ns/1ps
module spdif_enc_build
  import spdif_enc_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0]   sample,
  input  logic                  invalid,
  output logic [DATA_SLOTS-1:0] slots
);
  localparam int PAD = AUDIO_SLOTS - SAMPLE_W;
  localparam int SMP_LO = AUX_SLOTS + PAD;

  always_comb begin
    slots = '0;
    slots[SMP_LO +: SAMPLE_W] = sample;
    slots[V_SLOT] = invalid;
    // parity folded into first auxiliary slot; U, C, P stay 0
    slots[0] = ^{sample, invalid};
  end
endmodule

// File: rtl/spdif_enc_line.sv
`timescale 1ns/1ps
module spdif_enc_line
  import spdif_enc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cell_en,
  input  logic [5:0]            pos,
  input  logic [7:0]            pre_pat,
  input  logic [DATA_SLOTS-1:0] slots,
  output logic                  line
);
  logic [7:0]            pat_q;
  logic [DATA_SLOTS-1:0] slots_q;
  logic                  line_q;
  logic [7:0]            cur_pat;
  logic [DATA_SLOTS-1:0] cur_slots;
  logic [4:0]            slot_idx;
  logic                  next_cell;

  always_comb begin
    // at the first cell the fresh subframe is used directly
    cur_pat   = (pos == 6'd0) ? (pre_pat ^ {8{line_q}}) : pat_q;
    cur_slots = (pos == 6'd0) ? slots : slots_q;
    slot_idx  = pos[5:1] - 5'd4;
    if (pos < 6'(PRE_CELLS))
      next_cell = cur_pat[3'd7 - pos[2:0]];
    else if (!pos[0])
      next_cell = ~line_q;
    else
      next_cell = cur_slots[slot_idx] ? ~line_q : line_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      pat_q   <= '0;
      slots_q <= '0;
    end else if (cell_en) begin
      line_q <= next_cell;
      if (pos == 6'd0) begin
        pat_q   <= cur_pat;
        slots_q <= slots;
      end
    end
  end

  assign line = line_q;

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> $stable(line_q));
  // R3
  preamble_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && pos == 6'd0 |-> !line_q);
  // R4
  slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && pos >= 6'd8 && !pos[0] |=> line_q != $past(line_q));
endmodule

// File: rtl/spdif_subframe_enc.sv
`timescale 1ns/1ps
module spdif_subframe_enc
  import spdif_enc_pkg::*;
#(
  parameter int SAMPLE_W     = 16,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_en,
  input  logic                mute,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic                sdo
);
  localparam int SF_PER_BLOCK = 2 * BLOCK_FRAMES;

  logic [5:0]            pos;
  logic                  sf_start, is_left;
  pre_kind_e             kind;
  logic [SAMPLE_W-1:0]   hold_q;
  logic                  hold_full;
  logic                  accept;
  logic [SAMPLE_W-1:0]   cur_sample;
  logic                  cur_invalid;
  logic [DATA_SLOTS-1:0] slots;

  spdif_enc_seq #(.SF_PER_BLOCK(SF_PER_BLOCK)) u_seq (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en),
    .pos(pos), .sf_start(sf_start), .is_left(is_left), .kind(kind)
  );

  assign in_ready = cell_en && sf_start && is_left;
  assign accept   = in_ready && in_valid;

  always_comb begin
    if (is_left) begin
      cur_sample  = accept ? in_left : '0;
      cur_invalid = !accept || mute;
    end else begin
      cur_sample  = hold_full ? hold_q : '0;
      cur_invalid = !hold_full || mute;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (cell_en && sf_start) begin
      if (is_left) begin
        hold_full <= accept;
        if (accept) hold_q <= in_right;
      end else begin
        hold_full <= 1'b0;
      end
    end
  end

  spdif_enc_build #(.SAMPLE_W(SAMPLE_W)) u_build (
    .sample(cur_sample), .invalid(cur_invalid), .slots(slots)
  );

  spdif_enc_line u_line (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .pos(pos),
    .pre_pat(pre_cells(kind)), .slots(slots), .line(sdo)
  );

  // R7
  right_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> hold_full);
  // R8
  right_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en && sf_start && !is_left |=> !hold_full);
endmodule

// File: tb/test_spdif_subframe_enc.sv
`timescale 1ns/1ps
module test_spdif_subframe_enc;
  localparam int SW = 16;

  logic clk = 1'b0, rst_n = 1'b0, cell_en = 1'b0, mute = 1'b0, in_valid = 1'b0;
  logic [SW-1:0] in_left = '0, in_right = '0;
  logic in_ready, sdo;

  spdif_subframe_enc i_spdif_subframe_enc (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .mute(mute),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_right(in_right), .sdo(sdo)
  );

  always #2.5 clk = ~clk;

  typedef struct { int sf; logic [SW-1:0] l; logic [SW-1:0] r; } frame_t;
  frame_t expq[$];

  int errors = 0, checks = 0;
  int n = 0, cpos = 0, cyc = 0;
  bit gen_on = 0, stall = 0, done = 0;
  logic lvl = 1'b0, start_lvl = 1'b0, mute_sf = 1'b0;
  logic cells [64];
  logic pend_full = 1'b0;
  logic [SW-1:0] pend_r = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s (subframe %0d): actual=%h expected=%h", req, what, n, act, exp);
    end
  endtask

  // cell enable generator: two of three cycles, with stall windows
  initial forever begin
    @(negedge clk);
    cyc++;
    cell_en = gen_on && !stall && (cyc % 3 != 0);
  end

  task automatic decode();
    logic [7:0] pat, exp_pat;
    logic [27:0] dec, exp_d;
    logic prev, c0, c1, inv, v;
    logic [SW-1:0] smp;
    string tag;
    frame_t f;
    for (int i = 0; i < 8; i++) pat[7-i] = cells[i] ^ start_lvl;
    exp_pat = (n % 384 == 0) ? 8'hE8 : ((n % 2 == 1) ? 8'hE4 : 8'hE2);
    chk(pat == exp_pat, (n == 0) ? "R1" : "R2", "preamble", {24'd0, pat}, {24'd0, exp_pat});
    chk(start_lvl == 1'b0, "R3", "level entering preamble", {31'd0, start_lvl}, 32'd0);
    prev = cells[7];
    for (int i = 0; i < 28; i++) begin
      c0 = cells[8 + 2*i];
      c1 = cells[9 + 2*i];
      chk(c0 != prev, "R4", "slot start transition", {31'd0, c0}, {31'd0, ~prev});
      dec[i] = c1 ^ c0;
      prev = c1;
    end
    if (n % 2 == 0) begin
      if (expq.size() > 0 && expq[0].sf == n) begin
        f = expq.pop_front();
        smp = f.l; inv = 1'b0; pend_full = 1'b1; pend_r = f.r;
      end else begin
        smp = '0; inv = 1'b1; pend_full = 1'b0;
      end
    end else begin
      smp = pend_full ? pend_r : '0;
      inv = !pend_full;
      pend_full = 1'b0;
    end
    v = inv | mute_sf;
    exp_d = '0;
    exp_d[23:8] = smp;
    exp_d[24] = v;
    exp_d[0] = (^smp) ^ v;
    if (mute_sf)     tag = "R9";
    else if (inv)    tag = "R8";
    else if (n % 2)  tag = "R7";
    else             tag = "R5";
    chk(dec == exp_d, tag, "decoded slots", {4'd0, dec}, {4'd0, exp_d});
    chk(dec[27] == 1'b0 && (^dec) == 1'b0, "R6", "parity", {4'd0, dec}, {4'd0, exp_d});
  endtask

  // monitor
  initial forever begin
    logic en, rdy, mu;
    @(posedge clk);
    en = cell_en; rdy = in_ready; mu = mute;
    #1;
    if (rst_n && !done) begin
      chk(rdy == (en && cpos == 0 && n % 2 == 0), "R7", "ready timing", {31'd0, rdy},
          {31'd0, en && cpos == 0 && n % 2 == 0});
      if (!en) begin
        chk(sdo == lvl, "R10", "line held", {31'd0, sdo}, {31'd0, lvl});
      end else begin
        if (cpos == 0) begin start_lvl = lvl; mute_sf = mu; end
        cells[cpos] = sdo;
        lvl = sdo;
        cpos++;
        if (cpos == 64) begin
          decode();
          cpos = 0;
          n++;
        end
      end
    end
  end

  // driver: offers a frame and records it for the scoreboard once taken
  task automatic send_frame(input logic [SW-1:0] l, input logic [SW-1:0] r);
    frame_t f;
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r;
    do @(posedge clk); while (!in_ready);
    f.sf = n; f.l = l; f.r = r;
    expq.push_back(f);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sdo == 1'b0, "R1", "sdo after reset", {31'd0, sdo}, 32'd0);
    chk(in_ready == 1'b0, "R1", "ready after reset", {31'd0, in_ready}, 32'd0);
    gen_on = 1;
    wait (n >= 3);                       // R8 startup underrun
    send_frame(16'hFFFF, 16'h0000);
    send_frame(16'h0000, 16'hFFFF);
    send_frame(16'h8001, 16'h7FFE);
    send_frame(16'hAAAA, 16'h5555);
    send_frame(16'h0001, 16'h8000);
    mute = 1'b1;                         // R9
    send_frame(16'h1234, 16'hFEDC);
    send_frame(16'h00FF, 16'hFF00);
    mute = 1'b0;
    send_frame(16'h0F0F, 16'hF0F0);
    @(negedge clk); stall = 1;           // R10
    repeat (40) @(negedge clk);
    stall = 0;
    send_frame(16'hC3C3, 16'h3C3C);
    wait (n >= 40);                      // R8 mid-stream gap
    lf = 32'h1ACE_B00C;
    while (n < 780) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      send_frame(lf[15:0], lf[31:16]);
    end
    wait (n >= 790);
    finish_run();
  end
endmodule